// File: doc/BRIEF.md
# Bank-Switched Sequential MAC FIR Filter

This block is a time-multiplexed FIR filter built around one multiply-accumulate engine. The engine computes one tap product per clock. A table of coefficient sets is held on chip, and each set describes a response with its own passband width and centre frequency. A select code, taken with each input sample, picks the set that the engine loops over. The filter can therefore be switched from one sample to the next without reloading any coefficient memory. One select code bypasses the filter and passes the sample through unchanged.

Samples are offered with a valid/ready handshake. While the engine is working on a sample, the block holds further samples off by dropping ready. Past samples live in a circular RAM. Every accepted sample enters that history, whatever the select code, so the history is shared by all sets. The accumulator is wide enough that no sum of products can overflow. The result is rounded and then saturated back to the sample width.

The sizes are parameters: sample width, coefficient width, select width and tap-index width. With a tap-index width of `TAP_W`, each set has up to `TAPS = 2**TAP_W - 1` taps and each output takes `N = 2**TAP_W` cycles. With the default `TAP_W = 6` that is 63 taps and 64 cycles per output.

Top module: `bank_mac_fir`

## Requirements
- R1: After reset, `in_ready` is 1, `out_valid` is 0 and `out_data` is 0, and every delay-line entry holds zero.
- R2: A sample is accepted on a rising edge where `in_valid` and `in_ready` are both 1. `in_ready` is then 0 for the next `TAPS` cycles. It rises again in the final cycle of the computation, so that a new sample can be accepted on the same edge that delivers the output. A sample offered while `in_ready` is 0 is ignored and does not enter the delay line.
- R3: `out_valid` is a one-cycle pulse that appears exactly `N` clock edges after the accepting edge. Samples offered back to back therefore produce one output every `N` cycles.
- R4: For a select code s from 1 to 2**SEL_W-1, the output is `sat(round(sum over t = 0..TAPS-1 of c(s,t) * x[n-t]))`. Here `x[n]` is the sample just accepted, `x[n-t]` is the sample accepted t acceptances earlier, and samples from before reset count as zero.
- R5: The coefficient table is generated at elaboration and addressed as {select, tap}. For s ≥ 1, set s has length `L(s) = TAPS - ((s-1) mod 4)`. For t < L(s), c(s,t) is `(37*s + 23*t + 5) mod 2**COEF_W`, read as a two's-complement COEF_W-bit value. For t ≥ L(s), c(s,t) is 0.
- R6: The select code is sampled only on the accepting edge. Changes to `in_sel` or `in_data` during the computation have no effect on that output.
- R7: Select code 0 makes the output equal to the accepted sample, with the same latency as a filtered sample. The sample still enters the delay line.
- R8: Rounding adds `2**(COEF_W-2)` and then shifts arithmetically right by `COEF_W-1`. The result is clamped to the range from `-2**(SAMPLE_W-1)` to `2**(SAMPLE_W-1)-1`.
- R9: `out_data` changes only on the edge that raises `out_valid`, and it holds its value between pulses.
- R10: Switching to another select code takes effect on the very next sample. The new code works on the same shared history without any reload.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample offered |
| in_ready | output | 1 | Engine able to accept a sample |
| in_data | input | SAMPLE_W | Signed input sample |
| in_sel | input | SEL_W | Coefficient set code, 0 selects bypass |
| out_valid | output | 1 | One-cycle output strobe |
| out_data | output | SAMPLE_W | Signed, rounded and saturated result |

## Verification
The bench builds the block with 8-bit samples, 8-bit coefficients, a 3-bit select and a 3-bit tap index. That gives 7 taps, 8 cycles per output, and seven coefficient sets of lengths 7, 6, 5 and 4 plus bypass, small enough to sweep every select code over extreme, constant and varied samples. At these widths a run of full-scale samples drives the sum well past the output range, which brings both saturation limits and the rounding boundary within reach. Select codes that change from sample to sample exercise the shared history. Traffic offered while the engine is busy, back-to-back offers and the exact output timing are all covered.

// File: rtl/fir_pkg.sv
package fir_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RUN  = 2'd1,
      ST_DONE = 2'd2
   } fir_state_e;

   // Generated coefficient table entry for set sel, tap index tap.
   function automatic int coef_at(input int sel, input int tap,
                                  input int taps, input int cw);
      int v;
      if (sel == 0 || tap >= taps - ((sel - 1) % 4)) return 0;
      v = (sel * 37 + tap * 23 + 5) % (1 << cw);
      if (v >= (1 << (cw - 1))) v = v - (1 << cw);
      return v;
   endfunction

endpackage

// File: rtl/fir_coef_rom.sv
module fir_coef_rom #(
   parameter int SEL_W  = 5,
   parameter int TAP_W  = 6,
   parameter int COEF_W = 16,
   parameter int TAPS   = 63
) (
   input  logic [SEL_W-1:0]         sel,
   input  logic [TAP_W-1:0]         tap,
   output logic signed [COEF_W-1:0] coef
);
   localparam int DEPTH = 2 ** (SEL_W + TAP_W);

   logic signed [COEF_W-1:0] rom_w [DEPTH];

   for (genvar g = 0; g < DEPTH; g++) begin : g_entry
      assign rom_w[g] = COEF_W'(fir_pkg::coef_at(g >> TAP_W, g % (2 ** TAP_W),
                                                 TAPS, COEF_W));
   end

   assign coef = rom_w[{sel, tap}];
endmodule

// File: rtl/fir_delay_line.sv
module fir_delay_line #(
   parameter int SAMPLE_W = 16,
   parameter int TAP_W    = 6
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       wr_en,
   input  logic signed [SAMPLE_W-1:0] wr_data,
   input  logic [TAP_W-1:0]           rd_age,
   output logic signed [SAMPLE_W-1:0] rd_data
);
   localparam int DEPTH = 2 ** TAP_W;

   logic signed [SAMPLE_W-1:0] mem [DEPTH];
   logic [TAP_W-1:0]           wr_ptr_q;
   logic [TAP_W-1:0]           newest_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr_q <= '0;
         newest_q <= '0;
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else if (wr_en) begin
         mem[wr_ptr_q] <= wr_data;
         newest_q      <= wr_ptr_q;
         wr_ptr_q      <= wr_ptr_q + 1'b1;
      end
   end

   assign rd_data = mem[newest_q - rd_age];
endmodule

// File: rtl/fir_round_sat.sv
module fir_round_sat #(
   parameter int ACC_W    = 38,
   parameter int SHIFT    = 15,
   parameter int OUT_W    = 16,
   parameter bit ROUND_EN = 1'b1
) (
   input  logic signed [ACC_W-1:0] acc,
   output logic signed [OUT_W-1:0] y
);
   localparam logic signed [ACC_W-1:0] MAXV = ACC_W'((1 << (OUT_W - 1)) - 1);
   localparam logic signed [ACC_W-1:0] MINV = ~MAXV;

   logic signed [ACC_W-1:0] biased;
   logic signed [ACC_W-1:0] shifted;

   if (ROUND_EN) begin : g_round
      localparam logic signed [ACC_W-1:0] HALF = ACC_W'(1 << (SHIFT - 1));
      assign biased = acc + HALF;
   end else begin : g_trunc
      assign biased = acc;
   end

   assign shifted = biased >>> SHIFT;

   always_comb begin
      if (shifted > MAXV)      y = MAXV[OUT_W-1:0];
      else if (shifted < MINV) y = MINV[OUT_W-1:0];
      else                     y = shifted[OUT_W-1:0];
   end
endmodule

// File: rtl/bank_mac_fir.sv
module bank_mac_fir #(
   parameter int SAMPLE_W = 16,
   parameter int COEF_W   = 16,
   parameter int SEL_W    = 5,
   parameter int TAP_W    = 6,
   parameter bit ROUND_EN = 1'b1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       in_valid,
   output logic                       in_ready,
   input  logic signed [SAMPLE_W-1:0] in_data,
   input  logic [SEL_W-1:0]           in_sel,
   output logic                       out_valid,
   output logic signed [SAMPLE_W-1:0] out_data
);
   import fir_pkg::*;

   localparam int TAPS   = 2 ** TAP_W - 1;
   localparam int PROD_W = SAMPLE_W + COEF_W;
   localparam int ACC_W  = PROD_W + TAP_W;

   if (TAP_W < 3)                       begin : g_bad_tap  $error("TAP_W must be at least 3"); end
   if (SEL_W < 1)                       begin : g_bad_sel  $error("SEL_W must be at least 1"); end
   if (COEF_W < 2 || COEF_W > 30)       begin : g_bad_coef $error("COEF_W out of range"); end
   if (SAMPLE_W < 2 || SAMPLE_W > 30)   begin : g_bad_smp  $error("SAMPLE_W out of range"); end

   fir_state_e                 state_q;
   logic [TAP_W-1:0]           tap_q;
   logic [SEL_W-1:0]           sel_q;
   logic signed [SAMPLE_W-1:0] x_q;
   logic signed [ACC_W-1:0]    acc_q;
   logic signed [COEF_W-1:0]   coef;
   logic signed [SAMPLE_W-1:0] hist;
   logic signed [PROD_W-1:0]   prod;
   logic signed [SAMPLE_W-1:0] rs_y;
   logic                       accept;

   assign in_ready = (state_q != ST_RUN);
   assign accept   = in_valid && in_ready;
   assign prod     = coef * hist;

   fir_coef_rom #(.SEL_W(SEL_W), .TAP_W(TAP_W), .COEF_W(COEF_W), .TAPS(TAPS)) u_rom (
      .sel (sel_q),
      .tap (tap_q),
      .coef(coef)
   );

   fir_delay_line #(.SAMPLE_W(SAMPLE_W), .TAP_W(TAP_W)) u_hist (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (accept),
      .wr_data(in_data),
      .rd_age (tap_q),
      .rd_data(hist)
   );

   fir_round_sat #(.ACC_W(ACC_W), .SHIFT(COEF_W - 1), .OUT_W(SAMPLE_W),
                   .ROUND_EN(ROUND_EN)) u_rs (
      .acc(acc_q),
      .y  (rs_y)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         tap_q     <= '0;
         sel_q     <= '0;
         x_q       <= '0;
         acc_q     <= '0;
         out_valid <= 1'b0;
         out_data  <= '0;
      end else begin
         out_valid <= 1'b0;
         case (state_q)
            ST_RUN: begin
               acc_q <= acc_q + ACC_W'(prod);
               tap_q <= tap_q + 1'b1;
               if (tap_q == TAP_W'(TAPS - 1)) state_q <= ST_DONE;
            end
            default: begin
               if (state_q == ST_DONE) begin
                  out_valid <= 1'b1;
                  out_data  <= (sel_q == '0) ? x_q : rs_y;
               end
               if (accept) begin
                  state_q <= ST_RUN;
                  sel_q   <= in_sel;
                  x_q     <= in_data;
                  tap_q   <= '0;
                  acc_q   <= '0;
               end else begin
                  state_q <= ST_IDLE;
               end
            end
         endcase
      end
   end
endmodule

// File: rtl/fir_chk.sv
module fir_chk #(
   parameter int SAMPLE_W = 16,
   parameter int TAP_W    = 6
) (
   input logic                clk,
   input logic                rst_n,
   input logic                in_valid,
   input logic                in_ready,
   input logic                out_valid,
   input logic [SAMPLE_W-1:0] out_data
);
   localparam int N = 2 ** TAP_W;

   logic [TAP_W:0] win_q;

   always_ff @(posedge clk) begin
      if (!rst_n)                  win_q <= '0;
      else if (in_valid && in_ready) win_q <= 1;
      else if (win_q == (TAP_W+1)'(N)) win_q <= '0;
      else if (win_q != '0)        win_q <= win_q + 1'b1;
   end

   // R2
   ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> !in_ready);

   // R3
   single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |=> !out_valid);

   // R3
   latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (win_q == (TAP_W+1)'(N)) |=> out_valid);

   // R3
   no_early_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> ($past(win_q) == (TAP_W+1)'(N)));

   // R9
   hold_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> $stable(out_data));
endmodule

bind bank_mac_fir fir_chk #(.SAMPLE_W(SAMPLE_W), .TAP_W(TAP_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .in_valid (in_valid),
   .in_ready (in_ready),
   .out_valid(out_valid),
   .out_data (out_data)
);

// File: tb/bank_mac_fir_tb.sv
module bank_mac_fir_tb;
   localparam int SW   = 8;
   localparam int CW   = 8;
   localparam int SLW  = 3;
   localparam int TW   = 3;
   localparam int TAPS = 2 ** TW - 1;
   localparam int N    = 2 ** TW;

   logic                 clk = 1'b0;
   logic                 rst_n = 1'b0;
   logic                 in_valid = 1'b0;
   logic                 in_ready;
   logic signed [SW-1:0] in_data = '0;
   logic [SLW-1:0]       in_sel = '0;
   logic                 out_valid;
   logic signed [SW-1:0] out_data;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   int hist [TAPS];
   int exp_val [1024];
   int exp_cyc [1024];
   int wr_i = 0;
   int rd_i = 0;
   int last_out = 0;
   bit mon_en = 1'b0;
   bit done = 1'b0;

   bank_mac_fir #(.SAMPLE_W(SW), .COEF_W(CW), .SEL_W(SLW), .TAP_W(TW)) u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_data(in_data), .in_sel(in_sel), .out_valid(out_valid), .out_data(out_data)
   );

   always #5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // R5 coefficient formula
   function automatic int cf(input int s, input int t);
      int v;
      if (s == 0 || t >= TAPS - ((s - 1) % 4)) return 0;
      v = (37 * s + 23 * t + 5) % 256;
      if (v >= 128) v -= 256;
      return v;
   endfunction

   // R4 / R7 / R8 expected output after pushing x into history
   function automatic int model(input int s, input int x);
      int sum = 0;
      int r;
      if (s == 0) return x;
      for (int t = 0; t < TAPS; t++) sum += cf(s, t) * hist[t];
      r = (sum + 64) >>> 7;
      if (r > 127) r = 127;
      if (r < -128) r = -128;
      return r;
   endfunction

   task automatic send(input int x, input int s, input bit noise);
      while (!in_ready) @(negedge clk);
      in_valid = 1'b1;
      in_data  = x[SW-1:0];
      in_sel   = s[SLW-1:0];
      @(negedge clk);
      for (int t = TAPS - 1; t > 0; t--) hist[t] = hist[t-1];
      hist[0] = x;
      exp_val[wr_i] = model(s, x);
      exp_cyc[wr_i] = cyc;
      wr_i++;
      chk(in_ready == 1'b0, "R2 ready low after accept", int'(in_ready), 0);
      if (noise) begin
         // R6 / R2: busy-time offer with other data and select must be ignored
         in_data = ~in_data;
         in_sel  = in_sel + 1'b1;
         repeat (N - 3) begin
            @(negedge clk);
            chk(in_ready == 1'b0, "R2 ready low while busy", int'(in_ready), 0);
         end
      end
      in_valid = 1'b0;
   endtask

   always @(negedge clk) begin
      if (mon_en) begin
         if (out_valid) begin
            if (rd_i >= wr_i) begin
               chk(1'b0, "R3 unexpected output", int'(out_data), 0);
            end else begin
               chk(int'(out_data) == exp_val[rd_i], "R4 output value",
                   int'(out_data), exp_val[rd_i]);
               chk(cyc - exp_cyc[rd_i] == N, "R3 latency", cyc - exp_cyc[rd_i], N);
               rd_i++;
            end
            last_out = int'(out_data);
         end else begin
            chk(int'(out_data) == last_out, "R9 output hold", int'(out_data), last_out);
         end
      end
   end

   initial begin
      #1000000;
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", rd_i, wr_i);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      for (int t = 0; t < TAPS; t++) hist[t] = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(in_ready == 1'b1, "R1 ready after reset", int'(in_ready), 1);
      chk(out_valid == 1'b0, "R1 valid after reset", int'(out_valid), 0);
      chk(out_data == '0, "R1 data after reset", int'(out_data), 0);
      mon_en = 1'b1;
      // R1: first outputs use a zero history
      send(100, 3, 1'b0);
      // Per-set sweep: extremes drive R8 saturation, noise covers R6
      for (int s = 0; s < 8; s++) begin
         for (int i = 0; i < 24; i++) begin
            int x;
            case (i % 12)
               0, 1, 2, 3:    x = 127;
               4, 5, 6, 7:    x = -128;
               8:             x = 0;
               9:             x = 1;
               10:            x = -1;
               default:       x = s * 19 - 60;
            endcase
            if (i >= 12) x = ((i * 53 + s * 29) % 256) - 128;
            send(x, s, (i % 7) == 3);
         end
      end
      // R10 / R7: select changes every sample over the shared history
      for (int i = 0; i < 48; i++) send(((i * 71) % 256) - 128, i % 8, (i % 5) == 2);
      while (rd_i < wr_i) @(negedge clk);
      repeat (10) @(negedge clk);
      chk(rd_i == wr_i, "R3 output count", rd_i, wr_i);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule